// File: doc/BRIEF.md
# ATM Cell Receive Buffer with Selectable Flow-Control Flag

This block is the receive buffer on the physical-layer side of a UTOPIA cell interface. The line side writes bytes into it, one byte per cycle. It stores them as 53-byte cells and hands them in order to an ATM-layer device over an 8-bit read bus. Cell boundaries are counted from reset: the first byte written after reset starts cell 0, and every 53rd byte after that starts a new cell.

A single flow-control output changes meaning with the mode input. In single-device mode (mode low) the flag is always driven. It acts as an active-low empty indication at byte level: it is low when nothing is stored and high when at least one byte is waiting. In multi-device mode (mode high) the flag is driven only while the 5-bit read address matches the device address set by a parameter; at other times its output enable is low, which models a high-impedance pin. When driven, the flag is high only when a complete cell is stored whose first byte has not yet been read. Read requests are also gated by the address match in multi-device mode.

Both sides share one clock. The read data and start-of-cell outputs are registered.

Top module: `rx_cell_fifo`

## Requirements
- R1: After reset the buffer is empty, `rd_data` is 0, `rd_soc` is 0, and in single-device mode `flag_oe` is 1 and `flag_out` is 0.
- R2: With `mode_multi` low, `flag_oe` is 1 and `flag_out` is 1 exactly when at least one byte is stored. A low flag means empty.
- R3: Bytes are read in the order they were written. An accepted read on clock edge k shows its byte on `rd_data` after edge k.
- R4: `rd_soc` is 1 together with a read byte whose position in the write stream, counted from 0 after reset, is a multiple of 53. It is 0 with every other byte.
- R5: A read request while the buffer is empty is ignored. `rd_data` keeps its value, `rd_soc` goes to 0, and no later byte is lost.
- R6: The buffer holds `DEPTH_CELLS`*53 bytes (212 by default). A write while it is full is dropped and does not disturb the stored bytes.
- R7: With `mode_multi` high, `flag_oe` is 1 only while `rd_addr` equals `DEV_ADDR`. Otherwise `flag_oe` is 0 and `flag_out` is 0.
- R8: With `mode_multi` high and the address matching, `flag_out` is 1 exactly when a cell with all 53 bytes written is stored and its first byte has not been read. A cell with 52 bytes written does not count.
- R9: With `mode_multi` high, a read request is accepted only while `rd_addr` equals `DEV_ADDR`. Otherwise it is ignored, as in R5.
- R10: The level of `mode_multi` selects the mode: high means multi-device, low means single-device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_multi | input | 1 | 1 selects multi-device mode, 0 selects single-device mode |
| wr_en | input | 1 | Write strobe from the line side |
| wr_data | input | 8 | Byte to be stored |
| rd_en | input | 1 | Read request from the ATM layer |
| rd_addr | input | 5 | Device address presented by the ATM layer |
| rd_data | output | 8 | Byte read out (registered) |
| rd_soc | output | 1 | Marks the first byte of a cell on `rd_data` |
| flag_out | output | 1 | Empty flag (single mode) or cell-available flag (multi mode) |
| flag_oe | output | 1 | Output enable of the flag; 0 stands for high impedance |

## Verification
`rd_data` and `rd_soc` change on the clock edge that accepts a read. `flag_out` and `flag_oe` follow stored state one edge after the write or read that changes it, and they follow `rd_addr` and `mode_multi` at once through combinational logic. The bench drives every input on the falling edge and checks registered results on the next falling edge, half a period after the edge that caused them. It checks the combinational flags 1 ns after changing the address or mode. Expected bytes come from a queue model in the bench. Expected flags come from counts of bytes written and read, using the rule that a cell is available when the number of completed cells exceeds the number of cells already started.

// File: rtl/rx_cell_fifo_pkg.sv
package rx_cell_fifo_pkg;

  localparam int CELL_BYTES = 53;

  // Next index in a circular range 0..lim-1
  function automatic int wrap_inc(input int idx, input int lim);
    return (idx == lim - 1) ? 0 : idx + 1;
  endfunction

  // A whole, unstarted cell is present when the stored bytes cover the
  // rest of the cell being read, plus the partial cell being written,
  // plus at least one full cell.
  function automatic logic whole_cell_waiting(input int fill, input int wpos,
                                              input int rpos);
    int head_rest;
    head_rest = (rpos != 0) ? (CELL_BYTES - rpos) : 0;
    return fill >= (wpos + head_rest + CELL_BYTES);
  endfunction

endpackage

// File: rtl/rcf_store.sv
module rcf_store
  import rx_cell_fifo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DEPTH_BYTES = 212,
  parameter int FILL_W      = $clog2(DEPTH_BYTES + 1),
  parameter int POS_W       = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_req,
  output logic [DW-1:0]     rd_data,
  output logic              rd_soc,
  output logic [FILL_W-1:0] fill,
  output logic [POS_W-1:0]  wpos,
  output logic [POS_W-1:0]  rpos,
  output logic              wr_acc,
  output logic              rd_acc
);
  localparam int PTR_W = $clog2(DEPTH_BYTES);

  logic [DW-1:0]    mem [DEPTH_BYTES];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, empty;

  assign full   = (fill == FILL_W'(DEPTH_BYTES));
  assign empty  = (fill == '0);
  assign wr_acc = wr_en && !full;
  assign rd_acc = rd_req && !empty;

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      wpos <= '0;
    end else if (wr_acc) begin
      wptr <= PTR_W'(wrap_inc(int'(wptr), DEPTH_BYTES));
      wpos <= POS_W'(wrap_inc(int'(wpos), CELL_BYTES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rpos    <= '0;
      rd_data <= '0;
      rd_soc  <= 1'b0;
    end else begin
      rd_soc <= 1'b0;
      if (rd_acc) begin
        rd_data <= mem[rptr];
        rd_soc  <= (rpos == '0);
        rptr    <= PTR_W'(wrap_inc(int'(rptr), DEPTH_BYTES));
        rpos    <= POS_W'(wrap_inc(int'(rpos), CELL_BYTES));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill <= '0;
    else begin
      case ({wr_acc, rd_acc})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/rcf_flag.sv
module rcf_flag #(
  parameter int         AW       = 5,
  parameter logic [4:0] DEV_ADDR = 5'd3
) (
  input  logic          mode_multi,
  input  logic [AW-1:0] rd_addr,
  input  logic          has_byte,
  input  logic          has_cell,
  output logic          addr_hit,
  output logic          flag_out,
  output logic          flag_oe
);
  assign addr_hit = (rd_addr == AW'(DEV_ADDR));

  always_comb begin
    if (mode_multi) begin
      flag_oe  = addr_hit;
      flag_out = addr_hit && has_cell;
    end else begin
      flag_oe  = 1'b1;
      flag_out = has_byte;
    end
  end

endmodule

// File: rtl/rx_cell_fifo.sv
module rx_cell_fifo
  import rx_cell_fifo_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         AW          = 5,
  parameter int         DEPTH_CELLS = 4,
  parameter logic [4:0] DEV_ADDR    = 5'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_multi,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_soc,
  output logic          flag_out,
  output logic          flag_oe
);
  localparam int DEPTH_BYTES = DEPTH_CELLS * CELL_BYTES;
  localparam int FILL_W      = $clog2(DEPTH_BYTES + 1);
  localparam int POS_W       = $clog2(CELL_BYTES);

  logic [FILL_W-1:0] fill;
  logic [POS_W-1:0]  wpos, rpos;
  logic              wr_acc, rd_acc, rd_req, addr_hit;
  logic              has_byte, has_cell;

  assign rd_req   = rd_en && (!mode_multi || addr_hit);
  assign has_byte = (fill != '0);
  assign has_cell = whole_cell_waiting(int'(fill), int'(wpos), int'(rpos));

  rcf_store #(
    .DW(DW), .DEPTH_BYTES(DEPTH_BYTES), .FILL_W(FILL_W), .POS_W(POS_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .rd_soc(rd_soc), .fill(fill),
    .wpos(wpos), .rpos(rpos), .wr_acc(wr_acc), .rd_acc(rd_acc)
  );

  rcf_flag #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_flag (
    .mode_multi(mode_multi), .rd_addr(rd_addr), .has_byte(has_byte),
    .has_cell(has_cell), .addr_hit(addr_hit), .flag_out(flag_out),
    .flag_oe(flag_oe)
  );

endmodule

// File: rtl/rx_cell_fifo_chk.sv
module rx_cell_fifo_chk #(
  parameter int         DW          = 8,
  parameter int         AW          = 5,
  parameter int         DEPTH_BYTES = 212,
  parameter int         FILL_W      = 8,
  parameter logic [4:0] DEV_ADDR    = 5'd3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_multi,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic              rd_soc,
  input logic              flag_out,
  input logic              flag_oe,
  input logic [FILL_W-1:0] fill
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH_BYTES)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILL_W'(DEPTH_BYTES) && wr_en && !rd_en) |=> $stable(fill)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |=> ($stable(rd_data) && !rd_soc)); // R5
  AST_SOC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_soc |=> !rd_soc); // R4
  AST_SINGLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_multi |-> flag_oe); // R2
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_multi && fill == '0) |-> !flag_out); // R2
  AST_HIZ_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_multi && rd_addr != AW'(DEV_ADDR)) |-> (!flag_oe && !flag_out)); // R7
  AST_CLAV_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_multi && flag_out) |-> (fill >= FILL_W'(53))); // R8
  AST_MISS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_multi && rd_addr != AW'(DEV_ADDR)) |=> !rd_soc); // R9
endmodule

bind rx_cell_fifo rx_cell_fifo_chk #(
  .DW(DW), .AW(AW), .DEPTH_BYTES(DEPTH_BYTES), .FILL_W(FILL_W),
  .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .wr_en(wr_en),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_soc(rd_soc),
  .flag_out(flag_out), .flag_oe(flag_oe), .fill(fill)
);

// File: tb/sim_rx_cell_fifo.sv
`timescale 1ns/1ps
module sim_rx_cell_fifo;
  localparam int         CAP = 4 * 53;
  localparam logic [4:0] DEV = 5'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_multi = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [4:0] rd_addr = DEV;
  logic [7:0] rd_data;
  logic       rd_soc, flag_out, flag_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model_q[$];
  int         wr_total = 0;
  int         rd_total = 0;
  logic [7:0] last_data = '0;
  logic [7:0] pat = 8'h11;

  always #5 clk = ~clk;

  rx_cell_fifo #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_soc(rd_soc), .flag_out(flag_out), .flag_oe(flag_oe)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_byte();
    @(negedge clk);
    wr_en = 1'b1; wr_data = pat;
    if (model_q.size() < CAP) begin
      model_q.push_back(pat);
      wr_total++;
    end
    pat = pat * 8'd5 + 8'd7;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_byte(input string req);
    bit         acc;
    logic [7:0] exp_d;
    bit         exp_s;
    @(negedge clk);
    rd_en = 1'b1;
    acc = (model_q.size() != 0) && (!mode_multi || rd_addr == DEV);
    if (acc) begin
      exp_d = model_q.pop_front();
      exp_s = (rd_total % 53) == 0;
      rd_total++;
      last_data = exp_d;
    end else begin
      exp_d = last_data;
      exp_s = 1'b0;
    end
    @(negedge clk);
    rd_en = 1'b0;
    check(req, "rd_data", rd_data, exp_d);
    check(acc ? "R4" : req, "rd_soc", rd_soc, exp_s);
  endtask

  task automatic check_flag(input string req);
    bit exp_oe, exp_out;
    #1;
    if (mode_multi) begin
      exp_oe  = (rd_addr == DEV);
      exp_out = exp_oe && ((wr_total / 53) > ((rd_total + 52) / 53));
    end else begin
      exp_oe  = 1'b1;
      exp_out = model_q.size() != 0;
    end
    check(req, "flag_oe", flag_oe, exp_oe);
    check(req, "flag_out", flag_out, exp_out);
  endtask

  task automatic t_reset();
    check("R1", "rd_data", rd_data, 0);
    check("R1", "rd_soc", rd_soc, 0);
    check_flag("R1");
  endtask

  task automatic t_single();
    for (int i = 0; i < 5; i++) wr_byte();
    check_flag("R2");
    for (int i = 0; i < 5; i++) rd_byte("R3");
    check_flag("R2");
    rd_byte("R5");
    rd_byte("R5");
    wr_byte();
    check_flag("R2");
    rd_byte("R5");
  endtask

  task automatic t_multi();
    mode_multi = 1'b1; rd_addr = DEV;
    check_flag("R10");
    while (wr_total % 53 != 0) wr_byte();
    check_flag("R8");
    for (int i = 0; i < 52; i++) wr_byte();
    check_flag("R8");
    wr_byte();
    check_flag("R8");
    rd_addr = 5'd9;
    check_flag("R7");
    rd_byte("R9");
    rd_addr = DEV;
    check_flag("R8");
    rd_byte("R9");
    check_flag("R8");
    while (model_q.size() != 0) rd_byte("R3");
    check_flag("R8");
    rd_byte("R5");
  endtask

  task automatic t_full();
    mode_multi = 1'b0;
    for (int i = 0; i < CAP + 4; i++) wr_byte();
    check("R6", "stored", model_q.size(), CAP);
    check_flag("R2");
    while (model_q.size() != 0) rd_byte("R6");
    check_flag("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_full();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired, all R: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule